// File: doc/BRIEF.md
# Plausibility-Checked Set/Reset Control Latch Bank

This block holds a bank of stored control flags that feed a Boolean equation engine. Each channel has a level-sensitive set input and a level-sensitive reset input. Each of the two inputs also has a bit that says whether it has been assigned to a physical source. The channel keeps its flag after the set level goes away, which makes it different from the plain updating inputs of the equation logic.

A channel behaves as a real latch only while both of its inputs are assigned. If either input is unassigned, the channel output is forced to 1, which means "externally set". This forcing is combinational and takes effect in the same cycle. While a channel is forced, its stored state is frozen. When the channel is fully assigned again, it continues from that stored value.

If set and reset are high together, the request is implausible. The channel then keeps the last plausible stored value. Input debouncing is done elsewhere.

Top module: `ctrl_latch_bank`

## Requirements
- R1: The bank has `CHANNELS` channels (default 8). Each channel is independent: a channel's flag depends only on that channel's own set, reset and assignment bits.
- R2: A channel is armed when `set_cfg[i]` and `rst_cfg[i]` are both 1. If an armed channel samples `set_lvl[i]=1` and `rst_lvl[i]=0` at a rising clock edge, `flag[i]` is 1 after that edge. It stays 1 after the set level is removed.
- R3: If an armed channel samples `rst_lvl[i]=1` and `set_lvl[i]=0` at a rising edge, `flag[i]` is 0 after that edge.
- R4: If an armed channel samples both levels at 0, its stored state and `flag[i]` are unchanged.
- R5: If an armed channel samples both levels at 1 (implausible), it keeps the last plausible stored state.
- R6: When either `set_cfg[i]` or `rst_cfg[i]` is 0, `flag[i]` is 1 in the same cycle, whatever the levels are.
- R7: An active-low `rst_n` clears every stored state to 0. Armed channels then show 0, and unarmed channels show 1.
- R8: While a channel is unarmed, its stored state does not change. When the channel is armed again, `flag[i]` shows the value that was stored before the channel became unarmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_lvl | input | CHANNELS | Per-channel set level |
| rst_lvl | input | CHANNELS | Per-channel reset level |
| set_cfg | input | CHANNELS | Per-channel set input assigned |
| rst_cfg | input | CHANNELS | Per-channel reset input assigned |
| flag | output | CHANNELS | Per-channel control flag |

## Verification
The case that is hardest to reach from the ports is the frozen state behind a forced channel. While a channel is unarmed, its output is always 1, so a corrupted stored value stays hidden until the channel is armed again. The stimulus therefore clears a channel, disarms it, and drives set pulses and implausible pairs while it is disarmed. It then re-arms the channel and expects 0. Random runs draw the assignment bits with a bias toward armed, and they also flip them often enough that disarm/re-arm transitions appear after every kind of level pair.

// File: rtl/ctrl_latch_bank.sv
module ctrl_latch_bank #(
  parameter int CHANNELS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] set_lvl,
  input  logic [CHANNELS-1:0] rst_lvl,
  input  logic [CHANNELS-1:0] set_cfg,
  input  logic [CHANNELS-1:0] rst_cfg,
  output logic [CHANNELS-1:0] flag
);

  logic [CHANNELS-1:0] armed;
  logic [CHANNELS-1:0] held;
  logic [CHANNELS-1:0] go_hi;
  logic [CHANNELS-1:0] go_lo;

  assign armed = set_cfg & rst_cfg;
  assign go_hi = armed & set_lvl & ~rst_lvl;
  assign go_lo = armed & rst_lvl & ~set_lvl;

  // Any request other than a plausible set or clear leaves the bit alone.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else        held <= (held | go_hi) & ~go_lo;
  end

  assign flag = held | ~armed;

  for (genvar i = 0; i < CHANNELS; i++) begin : g_chk
    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_cfg[i] && rst_cfg[i] && set_lvl[i] && !rst_lvl[i]) |=> held[i]);
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (set_cfg[i] && rst_cfg[i] && rst_lvl[i] && !set_lvl[i]) |=> !held[i]);
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (set_cfg[i] && rst_cfg[i] && !set_lvl[i] && !rst_lvl[i]) |=> $stable(held[i]));
    assert_implausible_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (set_cfg[i] && rst_cfg[i] && set_lvl[i] && rst_lvl[i]) |=> $stable(held[i]));
    assert_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_cfg[i] && rst_cfg[i]) |-> flag[i]);
    assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_cfg[i] && rst_cfg[i]) |=> $stable(held[i]));
  end

endmodule

// File: tb/tb_ctrl_latch_bank.sv
module tb_ctrl_latch_bank;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] set_lvl = '0, rst_lvl = '0, set_cfg = '1, rst_cfg = '1;
  logic [N-1:0] flag;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] m_st = '0;
  int last_op [N];

  always #10 clk = ~clk;

  ctrl_latch_bank #(.CHANNELS(N)) dut (
    .clk(clk), .rst_n(rst_n), .set_lvl(set_lvl), .rst_lvl(rst_lvl),
    .set_cfg(set_cfg), .rst_cfg(rst_cfg), .flag(flag));

  function automatic logic exp_flag(logic st, logic a);
    return a ? st : 1'b1;
  endfunction

  function automatic string tag_of(int op, logic a);
    if (!a) return "R6";
    case (op)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic [N-1:0] sc, input logic [N-1:0] rc,
                       input logic [N-1:0] s, input logic [N-1:0] r, input int focus);
    @(negedge clk);
    set_cfg = sc; rst_cfg = rc; set_lvl = s; rst_lvl = r;
    #1;
    for (int i = 0; i < N; i++) begin
      logic a;
      logic e;
      string t;
      a = sc[i] & rc[i];
      e = exp_flag(m_st[i], a);
      t = (focus >= 0 && i != focus && a) ? "R1" : tag_of(last_op[i], a);
      checks++;
      if (flag[i] !== e) begin
        errors++;
        $display("FAIL %s ch%0d: flag=%b expected=%b", t, i, flag[i], e);
      end
      if (a) begin
        if (s[i] && !r[i]) begin m_st[i] = 1'b1; last_op[i] = 1; end
        else if (r[i] && !s[i]) begin m_st[i] = 1'b0; last_op[i] = 2; end
        else if (!s[i]) last_op[i] = 3;
        else last_op[i] = 4;
      end else last_op[i] = 5;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd24680));
    for (int i = 0; i < N; i++) last_op[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R7: reset state, some channels unassigned
    apply('1, 8'hF0, '0, '0, -1);
    // R2: set then release, level removed
    apply('1, '1, 8'hFF, 8'h00, -1);
    apply('1, '1, 8'h00, 8'h00, -1);
    // R5: implausible pair holds 1
    apply('1, '1, 8'hFF, 8'hFF, -1);
    // R3: clear
    apply('1, '1, 8'h00, 8'hFF, -1);
    // R1: only channel 3 set, others must stay
    apply('1, '1, 8'h08, 8'h00, -1);
    apply('1, '1, 8'h00, 8'h00, 3);
    // R8: disarm cleared ch0, drive set/implausible, then re-arm
    apply(8'hFE, 8'hFF, 8'h01, 8'h00, -1);
    apply(8'hFF, 8'hFE, 8'h01, 8'h01, -1);
    apply(8'hFE, 8'hFE, 8'h01, 8'h00, -1);
    apply('1, '1, 8'h00, 8'h00, -1);
    // R8: disarm set ch3, drive clear, then re-arm
    apply(8'hF7, 8'hFF, 8'h00, 8'h08, -1);
    apply('1, '1, 8'h00, 8'h00, -1);
    // Random mix
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] sc, rc;
      sc = 8'($urandom) | 8'($urandom) | 8'($urandom);
      rc = 8'($urandom) | 8'($urandom) | 8'($urandom);
      apply(sc, rc, 8'($urandom), 8'($urandom), -1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule